// File: doc/BRIEF.md
# Saturating Two-Tap Filter with Request/Acknowledge Control

This block filters a stream of 8-bit samples with a two-tap response: each output is four times the present sample plus three times the previous one, reduced modulo 256. The sum then goes through a two-level clamp. A set top bit sends the output to zero. Otherwise a set second bit caps the output at 0x3F. The delayed tap is not held as a raw sample. It is held as the product three times that sample, computed when the sample arrives and kept until the next one.

Samples are moved by a four-phase request/acknowledge handshake, which also provides the back-pressure. The producer places a sample on `sample` and raises `start`. The block takes the sample on the first clock edge where it sees `start` high while `done` is low. On that edge it updates `result` and raises `done`. The producer must keep `start` high until it sees `done`, then lower it. The block clears `done` on the first edge where it sees `start` low. A new sample is accepted only after `done` has fallen, so the producer cannot outrun the filter. The value of `sample` matters only on the accepting edge.

Top module: `sat_fir2`

## Requirements
- R1: While `rst_n` is low, `done` is 0, `result` is 0x00 and the stored tap is 0. As a result, the first output after reset depends only on four times the first sample.
- R2: On an accepting edge, the unclamped sum is (4·sample + stored tap) mod 256. The stored tap used here is the value from before this edge.
- R3: On each accepting edge, the stored tap becomes (3·sample) mod 256. The next sum uses this value.
- R4: If bit 7 of the unclamped sum is 1, `result` is 0x00.
- R5: If bit 7 of the unclamped sum is 0 and bit 6 is 1, `result` is 0x3F. Together with R4 and R6, this means `result` bits 7 and 6 are never set.
- R6: If bits 7 and 6 of the unclamped sum are both 0, `result` equals the sum.
- R7: When `start` is high and `done` is low at a clock edge, that edge is an accepting edge and `done` is 1 after it.
- R8: `done` stays 1 while `start` stays high. It returns to 0 on the first edge where `start` is seen low.
- R9: `result` changes only on an accepting edge. It holds its value while `done` is high and while the block is idle.
- R10: Holding `start` high after `done` has risen does not start another computation: the stored tap and `result` are unchanged.
- R11: Changes on `sample` outside an accepting edge have no effect on `result` or on the stored tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request: a sample is presented |
| sample | input | 8 | Input sample, read on the accepting edge |
| done | output | 1 | Acknowledge: result is valid |
| result | output | 8 | Clamped filter output |

## Verification
The sample set is chosen so that every clamp branch is hit, along with products that wrap past 256. A block that clamped before reducing, or that tested the bits in the wrong order, would return 0x3F where 0x00 is due. Long requests with a changing sample target double acceptance: a block that recomputed while `start` stayed high would advance the stored tap and corrupt the following output. The bench also checks that the first output after reset sees a zero tap, and that a block summing the new tap instead of the old one gives a wrong value on the very first pair of samples.

// File: rtl/sat_fir_pkg.sv
package sat_fir_pkg;
  // Gains of the two taps.
  localparam int unsigned CUR_GAIN  = 4;
  localparam int unsigned PREV_GAIN = 3;

  // Handshake phase of the controller.
  typedef enum logic {
    PH_WAIT_REQ = 1'b0,
    PH_HOLD_ACK = 1'b1
  } hs_phase_t;
endpackage

// File: rtl/fir_hs_ctrl.sv
module fir_hs_ctrl
  import sat_fir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic done
);
  hs_phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    accept  = 1'b0;
    unique case (phase_q)
      PH_WAIT_REQ: if (start) begin
        accept  = 1'b1;
        phase_d = PH_HOLD_ACK;
      end
      PH_HOLD_ACK: if (!start) phase_d = PH_WAIT_REQ;
      default: phase_d = PH_WAIT_REQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_WAIT_REQ;
    else        phase_q <= phase_d;
  end

  assign done = (phase_q == PH_HOLD_ACK);
endmodule

// File: rtl/fir_tap_path.sv
module fir_tap_path
  import sat_fir_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] raw_sum
);
  localparam int unsigned PW = 2 * DATA_W;

  logic [DATA_W-1:0] tap_q;
  logic [PW-1:0]     wide_x;
  logic [PW-1:0]     cur_prod;
  logic [PW-1:0]     prev_prod;
  logic [PW-1:0]     wide_sum;

  assign wide_x    = PW'(sample);
  assign cur_prod  = wide_x * PW'(CUR_GAIN);
  assign prev_prod = wide_x * PW'(PREV_GAIN);
  assign wide_sum  = cur_prod + PW'(tap_q);
  assign raw_sum   = wide_sum[DATA_W-1:0];

  // Delayed tap held as a precomputed product, truncated to DATA_W.
  always_ff @(posedge clk) begin
    if (!rst_n)      tap_q <= '0;
    else if (accept) tap_q <= prev_prod[DATA_W-1:0];
  end
endmodule

// File: rtl/fir_clamp.sv
module fir_clamp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] clamped
);
  localparam logic [DATA_W-1:0] CAP = {2'b00, {(DATA_W-2){1'b1}}};

  always_comb begin
    if (raw[DATA_W-1])      clamped = '0;
    else if (raw[DATA_W-2]) clamped = CAP;
    else                    clamped = raw;
  end
endmodule

// File: rtl/sat_fir2.sv
module sat_fir2 #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] sample,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic              accept;
  logic [DATA_W-1:0] raw_sum;
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] result_q;

  fir_hs_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .done   (done)
  );

  fir_tap_path #(.DATA_W(DATA_W)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .sample  (sample),
    .raw_sum (raw_sum)
  );

  fir_clamp #(.DATA_W(DATA_W)) u_clamp (
    .raw     (raw_sum),
    .clamped (clamped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      result_q <= '0;
    else if (accept) result_q <= clamped;
  end

  assign result = result_q;
endmodule

// File: rtl/sat_fir2_checker.sv
module sat_fir2_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [DATA_W-1:0] result
);
  // R7: a request seen while idle is acknowledged on the next cycle
  assert_ack_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !done) |=> done);

  // R8: acknowledge held while the request is held
  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  // R8: acknowledge released once the request is withdrawn
  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R9: output moves only on an accepting edge
  assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !done) |=> $stable(result));

  // R5: clamp leaves both top bits clear
  assert_clamp_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[DATA_W-1:DATA_W-2] == 2'b00));
endmodule

bind sat_fir2 sat_fir2_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .done   (done),
  .result (result)
);

// File: tb/sat_fir2_test.sv
module sat_fir2_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] sample = 8'h00;
  logic       done;
  logic [7:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] tap_model = 8'h00;
  logic [7:0] exp_q[$];
  logic       prev_done = 1'b0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  sat_fir2 uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample(sample),
    .done(done), .result(result)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_step(input logic [7:0] x);
    logic [7:0] sum;
    sum = 8'((4 * int'(x) + int'(tap_model)) % 256);   // R2
    tap_model = 8'((3 * int'(x)) % 256);               // R3
    if (sum[7])      return 8'h00;                      // R4
    else if (sum[6]) return 8'h3F;                      // R5
    else             return sum;                        // R6
  endfunction

  // Driver: pushes expected item, runs one handshake.
  task automatic drive(input logic [7:0] x, input int hold, input int idle);
    logic [7:0] held;
    @(negedge clk);
    sample = x;
    start  = 1'b1;
    exp_q.push_back(model_step(x));
    @(negedge clk);
    check("R7 done after accept", {7'd0, done}, 8'd1);
    held = result;
    for (int i = 0; i < hold; i++) begin
      sample = sample ^ 8'h5A;               // R10 R11: ignored while held
      @(negedge clk);
      check("R8 done held", {7'd0, done}, 8'd1);
      check("R9 result held", result, held);
    end
    start = 1'b0;
    @(negedge clk);
    check("R8 done released", {7'd0, done}, 8'd0);
    for (int i = 0; i < idle; i++) begin
      sample = 8'(i * 37 + 11);              // R11: idle sample changes
      @(negedge clk);
      check("R11 idle result", result, held);
      check("R11 idle done", {7'd0, done}, 8'd0);
    end
  endtask

  // Monitor: compares on each rising acknowledge.
  always @(negedge clk) begin
    if (rst_n && done && !prev_done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 actual=%h expected=none", result);
      end else begin
        check("R2 R4 R5 R6 output", result, exp_q.pop_front());
      end
    end
    prev_done <= done;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", {7'd0, done}, 8'd0);
    check("R1 reset result", result, 8'h00);
    rst_n = 1'b1;
    drive(8'h05, 0, 1);   // 20, first after reset: zero tap (R1)
    drive(8'h10, 2, 0);   // 64+15 -> bit6 (R5)
    drive(8'h20, 1, 2);   // 128+48 -> bit7 (R4)
    drive(8'h01, 0, 0);   // 4+96 -> bit6
    drive(8'h00, 3, 1);   // 0+3 -> raw (R6)
    drive(8'h0A, 0, 0);   // 40+0 -> raw
    drive(8'h50, 4, 0);   // wraps: 64+30 -> bit6
    drive(8'hFF, 0, 3);   // wraps -> bit7
    drive(8'h40, 1, 0);   // 0+253 -> bit7
    drive(8'h02, 0, 0);   // 8+192 -> bit7
    drive(8'h07, 5, 1);   // 28+6 -> raw
    drive(8'h08, 0, 0);   // 32+21 = 53 raw
    drive(8'h0C, 0, 0);   // 48+24 = 72 -> bit6
    repeat (3) @(negedge clk);
    check("R2 queue drained", 8'(exp_q.size()), 8'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule